// File: doc/BRIEF.md
# SuperSpeed PHY Power Sequencer

This block walks the control bits of a SuperSpeed serial PHY through a fixed power-up order and a fixed power-down order. A one-cycle start pulse begins power-up. The block pulses PHY reset for a programmed number of cycles and then releases it. Next it selects the reference source, choosing the pad clock when an external crystal is reported present. It then waits a long, programmed settle time, and finally turns on the PHY enable and the lane-0 power-present bits in the same cycle.

After enabling the PHY, the block asks an external requester to program the lane equalizer and drive overrides. It holds that request, with the settings to apply, until the requester answers with a done strobe. A separate shutdown pulse runs three ordered steps, one per cycle: drop PHY enable, drop the pad reference select, then raise test-powerdown so the PHY enters retention.

While a sequence runs, the block reports itself busy and ignores any new command. A single-cycle done pulse marks the end of each sequence. Both wait lengths are parameters counted in clock cycles.

Top module: `ssphy_pwr_seq`

## Requirements
- R1: After reset, `ctl_word`, `busy`, `done`, `eq_req` and `eq_cfg` are all zero and the block is idle.
- R2: An init command sampled while idle sets PHY reset (`ctl_word` bit 7) in the next cycle and holds it for exactly RST_CYC cycles. While reset is high, bits 28, 27, 24 and 8 keep their prior values. An init never changes test-powerdown.
- R3: One cycle after reset is released, bit 28 (reference from pad) takes the value of `xtal_present` sampled at that edge.
- R4: SETTLE_CYC cycles after the bit-28 update, bit 8 (PHY enable) and bit 24 (lane-0 power present) are both 1, and `eq_req` rises in the same cycle.
- R5: While `eq_req` is high, it stays high until `eq_done` is sampled. During that time `eq_cfg` carries these fields: [2:0] RX equalizer value = 3, [3] RX equalizer override = 1, [4] equalizer enable value = 0, [5] equalizer enable override = 1, [11:6] TX pre-emphasis = 22, [18:12] TX amplitude = 127, [19] TX drive override = 1. Whenever `eq_req` is low, `eq_cfg` is zero.
- R6: The cycle after `eq_done` is sampled during the request, `done` is 1 for one cycle, and `busy` and `eq_req` are 0.
- R7: An exit command sampled while idle clears bit 8 in the next cycle, clears bit 28 in the cycle after that, and sets bit 27 (test-powerdown) with a one-cycle `done` in the third cycle. Bit 24 is left unchanged.
- R8: `busy` is 1 from the cycle after a command until the cycle that shows `done`. Init or exit commands sampled while busy have no effect on `ctl_word` or on the sequence timing. While idle with no command, `ctl_word` does not change.
- R9: When init and exit are sampled together while idle, init is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_cmd | input | 1 | Start power-up sequence |
| exit_cmd | input | 1 | Start power-down sequence |
| xtal_present | input | 1 | External crystal reference available |
| eq_done | input | 1 | Equalizer programming finished |
| ctl_word | output | 32 | PHY control bits (28 pad ref, 27 powerdown, 24 lane power, 8 enable, 7 reset) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| eq_req | output | 1 | Equalizer programming request |
| eq_cfg | output | 20 | Equalizer and drive override settings |

## Verification
A wrong state register or a timer off by one shows at `ctl_word` as a reset pulse or settle wait of the wrong length. The bench therefore checks the cycles just before and just after each bit edge, so a one-cycle slip fails at the first transition it affects. A state that wrongly accepts a command mid-sequence shows up within one cycle as a reset bit raised again or the enable bit dropped. A sequence that skips a step shows up at the exit bits within three cycles, or at the `done`/`eq_req` pair on the cycle after the handshake.

// File: rtl/ssphy_seq_pkg.sv
package ssphy_seq_pkg;

  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned BIT_PAD  = 28;
  localparam int unsigned BIT_PD   = 27;
  localparam int unsigned BIT_LANE = 24;
  localparam int unsigned BIT_EN   = 8;
  localparam int unsigned BIT_RST  = 7;

  localparam int unsigned RXEQ_W   = 3;
  localparam int unsigned PREEM_W  = 6;
  localparam int unsigned AMP_W    = 7;
  localparam int unsigned EQ_CFG_W = RXEQ_W + 3 + PREEM_W + AMP_W + 1;

  localparam logic [RXEQ_W-1:0]  RXEQ_VAL  = RXEQ_W'(3);
  localparam logic [PREEM_W-1:0] PREEM_VAL = PREEM_W'(22);
  localparam logic [AMP_W-1:0]   AMP_VAL   = AMP_W'(127);

  // tx override, amplitude, pre-emphasis, eq-en override, eq-en value, rx override, rx value
  localparam logic [EQ_CFG_W-1:0] EQ_CFG_VAL =
    {1'b1, AMP_VAL, PREEM_VAL, 1'b1, 1'b0, 1'b1, RXEQ_VAL};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_REF,
    ST_SETTLE,
    ST_EQ,
    ST_XPAD,
    ST_XPD
  } seq_state_e;

  typedef struct packed {
    logic pad;
    logic pd;
    logic lane;
    logic en;
    logic rst;
  } ctl_bits_t;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (run && (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import ssphy_seq_pkg::*;
#(
  parameter int unsigned W          = 8,
  parameter int unsigned RST_CYC    = 4,
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_cmd,
  input  logic         exit_cmd,
  input  logic         xtal_present,
  input  logic         eq_done,
  input  logic         tmr_expired,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  output logic         tmr_run,
  output ctl_bits_t    ctl,
  output logic         busy,
  output logic         done,
  output logic         eq_req
);

  localparam logic [W-1:0] RST_LOAD    = W'(RST_CYC - 1);
  localparam logic [W-1:0] SETTLE_LOAD = W'(SETTLE_CYC - 1);

  seq_state_e state_q, state_n;
  ctl_bits_t  ctl_q, ctl_n;
  logic       done_q, done_n;

  always_comb begin
    state_n  = state_q;
    ctl_n    = ctl_q;
    done_n   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_run  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (init_cmd) begin
          ctl_n.rst = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = RST_LOAD;
          state_n   = ST_RST;
        end else if (exit_cmd) begin
          ctl_n.en = 1'b0;
          state_n  = ST_XPAD;
        end
      end
      ST_RST: begin
        tmr_run = 1'b1;
        if (tmr_expired) begin
          ctl_n.rst = 1'b0;
          state_n   = ST_REF;
        end
      end
      ST_REF: begin
        ctl_n.pad = xtal_present;
        tmr_load  = 1'b1;
        tmr_val   = SETTLE_LOAD;
        state_n   = ST_SETTLE;
      end
      ST_SETTLE: begin
        tmr_run = 1'b1;
        if (tmr_expired) begin
          ctl_n.en   = 1'b1;
          ctl_n.lane = 1'b1;
          state_n    = ST_EQ;
        end
      end
      ST_EQ: begin
        if (eq_done) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      ST_XPAD: begin
        ctl_n.pad = 1'b0;
        state_n   = ST_XPD;
      end
      ST_XPD: begin
        ctl_n.pd = 1'b1;
        done_n   = 1'b1;
        state_n  = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ctl_q   <= ctl_n;
      done_q  <= done_n;
    end
  end

  assign ctl    = ctl_q;
  assign done   = done_q;
  assign busy   = (state_q != ST_IDLE);
  assign eq_req = (state_q == ST_EQ);

endmodule

// File: rtl/ctl_word_map.sv
module ctl_word_map
  import ssphy_seq_pkg::*;
(
  input  ctl_bits_t         ctl,
  input  logic              eq_req,
  output logic [CTRL_W-1:0] word,
  output logic [EQ_CFG_W-1:0] eq_cfg
);

  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    if (b == BIT_PAD) begin : g_pad
      assign word[b] = ctl.pad;
    end else if (b == BIT_PD) begin : g_pd
      assign word[b] = ctl.pd;
    end else if (b == BIT_LANE) begin : g_lane
      assign word[b] = ctl.lane;
    end else if (b == BIT_EN) begin : g_en
      assign word[b] = ctl.en;
    end else if (b == BIT_RST) begin : g_rst
      assign word[b] = ctl.rst;
    end else begin : g_zero
      assign word[b] = 1'b0;
    end
  end

  assign eq_cfg = eq_req ? EQ_CFG_VAL : '0;

endmodule

// File: rtl/ssphy_pwr_seq.sv
module ssphy_pwr_seq
  import ssphy_seq_pkg::*;
#(
  parameter int unsigned RST_CYC    = 200000,
  parameter int unsigned SETTLE_CYC = 3000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_cmd,
  input  logic                exit_cmd,
  input  logic                xtal_present,
  input  logic                eq_done,
  output logic [CTRL_W-1:0]   ctl_word,
  output logic                busy,
  output logic                done,
  output logic                eq_req,
  output logic [EQ_CFG_W-1:0] eq_cfg
);

  localparam int unsigned MAX_CYC = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_run;
  logic             tmr_expired;
  ctl_bits_t        ctl;

  seq_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expired  (tmr_expired)
  );

  seq_fsm #(
    .W          (CNT_W),
    .RST_CYC    (RST_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_cmd     (init_cmd),
    .exit_cmd     (exit_cmd),
    .xtal_present (xtal_present),
    .eq_done      (eq_done),
    .tmr_expired  (tmr_expired),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .tmr_run      (tmr_run),
    .ctl          (ctl),
    .busy         (busy),
    .done         (done),
    .eq_req       (eq_req)
  );

  ctl_word_map u_map (
    .ctl    (ctl),
    .eq_req (eq_req),
    .word   (ctl_word),
    .eq_cfg (eq_cfg)
  );

endmodule

// File: rtl/ssphy_pwr_seq_chk.sv
module ssphy_pwr_seq_chk
  import ssphy_seq_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                init_cmd,
  input logic                exit_cmd,
  input logic                eq_done,
  input logic [CTRL_W-1:0]   ctl_word,
  input logic                busy,
  input logic                done,
  input logic                eq_req
);

  // R6
  done_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  en_with_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_word[BIT_EN]) |-> (ctl_word[BIT_LANE] && busy && eq_req));

  // R7
  pd_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_word[BIT_PD]) |-> (done && !ctl_word[BIT_EN] && !ctl_word[BIT_PAD]));

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !init_cmd && !exit_cmd) |=> $stable(ctl_word));

  // R2
  rst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_word[BIT_RST] |-> (busy && !eq_req && !done));

  // R5
  eq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_req && !eq_done) |=> eq_req);

endmodule

bind ssphy_pwr_seq ssphy_pwr_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .init_cmd (init_cmd),
  .exit_cmd (exit_cmd),
  .eq_done  (eq_done),
  .ctl_word (ctl_word),
  .busy     (busy),
  .done     (done),
  .eq_req   (eq_req)
);

// File: tb/sim_ssphy_pwr_seq.sv
`timescale 1ns/1ps
module sim_ssphy_pwr_seq;

  localparam int RT = 20;
  localparam int ST = 50;
  localparam logic [19:0] EQ_EXP = 20'(3) | (20'(1) << 3) | (20'(1) << 5) |
                                   (20'(22) << 6) | (20'(127) << 12) | (20'(1) << 19);

  logic clk = 1'b0;
  logic rst_n;
  logic init_cmd, exit_cmd, xtal_present, eq_done;
  logic [31:0] ctl_word;
  logic busy, done, eq_req;
  logic [19:0] eq_cfg;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic m_pad, m_pd, m_lane, m_en;

  typedef struct {
    int          cyc;
    logic [31:0] word;
    logic        busy;
    logic        done;
    logic        eqr;
    logic [19:0] cfg;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  ssphy_pwr_seq #(.RST_CYC(RT), .SETTLE_CYC(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .init_cmd(init_cmd), .exit_cmd(exit_cmd),
    .xtal_present(xtal_present), .eq_done(eq_done), .ctl_word(ctl_word),
    .busy(busy), .done(done), .eq_req(eq_req), .eq_cfg(eq_cfg)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mkw(logic pad, logic pd, logic lane, logic en, logic rst);
    logic [31:0] w = '0;
    w[28] = pad; w[27] = pd; w[24] = lane; w[8] = en; w[7] = rst;
    return w;
  endfunction

  task automatic push(int c, logic [31:0] w, logic b, logic d, logic e, string tag);
    exp_t it;
    it.cyc = c; it.word = w; it.busy = b; it.done = d; it.eqr = e;
    it.cfg = e ? EQ_EXP : 20'd0; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      exp_t it;
      it = sbq.pop_front();
      checks++;
      if (it.cyc != cyc || ctl_word !== it.word || busy !== it.busy ||
          done !== it.done || eq_req !== it.eqr || eq_cfg !== it.cfg) begin
        errors++;
        $display("FAIL %s cyc=%0d: word=%h busy=%b done=%b eqr=%b cfg=%h expected cyc=%0d word=%h busy=%b done=%b eqr=%b cfg=%h",
                 it.tag, cyc, ctl_word, busy, done, eq_req, eq_cfg,
                 it.cyc, it.word, it.busy, it.done, it.eqr, it.cfg);
      end
    end
  end

  task automatic run_init(logic xtal, int gap, bit both);
    int t0, te;
    logic [31:0] base, refw, fin;
    t0   = cyc + 1;
    base = mkw(m_pad, m_pd, m_lane, m_en, 1'b0);
    refw = mkw(xtal, m_pd, m_lane, m_en, 1'b0);
    fin  = mkw(xtal, m_pd, 1'b1, 1'b1, 1'b0);
    te   = t0 + RT + 1 + ST;
    push(t0, base | mkw(0, 0, 0, 0, 1), 1, 0, 0, both ? "R9" : "R2");
    push(t0 + RT - 1, base | mkw(0, 0, 0, 0, 1), 1, 0, 0, "R2");
    push(t0 + RT, base, 1, 0, 0, "R2");
    push(t0 + RT + 1, refw, 1, 0, 0, "R3");
    push(t0 + RT + 3, refw, 1, 0, 0, "R8");
    push(t0 + RT + ST, refw, 1, 0, 0, "R4");
    push(te, fin, 1, 0, 1, "R4");
    push(te + gap, fin, 1, 0, 1, "R5");
    push(te + gap + 1, fin, 0, 1, 0, "R6");
    push(te + gap + 2, fin, 0, 0, 0, "R6");
    init_cmd = 1'b1; exit_cmd = both; xtal_present = xtal;
    @(negedge clk);
    init_cmd = 1'b0; exit_cmd = 1'b0;
    while (cyc < t0 + RT + 2) @(negedge clk);
    // commands while busy must be ignored (R8)
    init_cmd = 1'b1; exit_cmd = 1'b1; xtal_present = !xtal;
    @(negedge clk);
    init_cmd = 1'b0; exit_cmd = 1'b0;
    while (cyc < te + gap) @(negedge clk);
    eq_done = 1'b1;
    @(negedge clk);
    eq_done = 1'b0;
    repeat (3) @(negedge clk);
    m_pad = xtal; m_en = 1'b1; m_lane = 1'b1;
  endtask

  task automatic run_exit();
    int t0;
    t0 = cyc + 1;
    push(t0,     mkw(m_pad, m_pd, m_lane, 0, 0), 1, 0, 0, "R7");
    push(t0 + 1, mkw(0, m_pd, m_lane, 0, 0),     1, 0, 0, "R7");
    push(t0 + 2, mkw(0, 1, m_lane, 0, 0),        0, 1, 0, "R7");
    push(t0 + 3, mkw(0, 1, m_lane, 0, 0),        0, 0, 0, "R8");
    exit_cmd = 1'b1;
    @(negedge clk);
    exit_cmd = 1'b0; init_cmd = 1'b1;
    @(negedge clk);
    init_cmd = 1'b0;
    repeat (4) @(negedge clk);
    m_pad = 1'b0; m_en = 1'b0; m_pd = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; init_cmd = 1'b0; exit_cmd = 1'b0; xtal_present = 1'b0; eq_done = 1'b0;
    m_pad = 1'b0; m_pd = 1'b0; m_lane = 1'b0; m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(cyc + 2, 32'd0, 0, 0, 0, "R1");
    repeat (4) @(negedge clk);
    run_init(1'b1, 5, 1'b0);
    run_exit();
    run_init(1'b0, 1, 1'b0);
    run_exit();
    run_init(1'b1, 3, 1'b1);
    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL %s: pending=%0d expected pending=0", sbq[0].tag, sbq.size());
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R6 watchdog: cycles=%0d expected completion before 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule